// File: doc/BRIEF.md
# Three-Wire Half-Duplex Serial Master

This block is a host-side engine for a serial peripheral wired with three signals: an active-high chip enable, a serial clock, and a single data line that both ends drive in turn. A request carries a command byte, a read/write direction and a byte count. The engine raises the enable, shifts the command out, and then either sends the requested number of bytes or releases the data line and clocks in the requested number of bytes from the peripheral. All bytes travel least significant bit first, and the whole transaction sits inside one enable pulse.

Write bytes come in and read bytes go out through valid/ready handshakes. When the host side is not ready, the serial clock is held low between bytes, so the peripheral never sees a short or missing pulse. The serial clock rate comes from the system clock frequency and a speed selection parameter. The fast setting stays at or below 2 MHz. The slow setting gives 500 kHz for low-voltage supplies.

Top module: `tw_serial_master`

## Requirements
- R1: After reset and between transactions the outputs rest as follows: `ce` low, `sclk` low, `dq_oe` low, `busy` low and `req_ready` high.
- R2: The command byte and every write byte go out least significant bit first. The slave sees bit k of a byte at the k-th rising `sclk` edge of that byte.
- R3: The master changes `dq_o` only while `sclk` is low. The bit in place at each rising `sclk` edge is the bit the slave samples.
- R4: During a read the master samples `dq_i` at the end of each low phase, just before `sclk` rises. The first bit received is the least significant bit of the read byte.
- R5: A transaction has exactly one `ce` pulse. That pulse holds exactly 8 + 8·N rising `sclk` edges, where N is the byte count.
- R6: For a read, `dq_oe` drops at the falling `sclk` edge that ends the eighth command bit. It stays low for the whole read data phase.
- R7: Each high phase of `sclk` lasts HALF system cycles, and each low phase lasts at least HALF. HALF is ceil(SYS_HZ / (2·f)), with f = 2 MHz by default, which gives 13 cycles at 50 MHz.
- R8: With LOW_VOLT = 1, f is 500 kHz, which gives HALF = 50 cycles at 50 MHz.
- R9: A byte count of N from 1 to 2^LEN_W−1 moves N bytes in one burst. A count of 0 sends only the command byte.
- R10: `busy` is high from the cycle after a request is accepted until `ce` falls. While busy, `req_ready` is low and any new request is ignored.
- R11: Between write bytes `wr_ready` is high with `sclk` low and `ce` high. The clock waits as long as `wr_valid` stays low.
- R12: `rd_valid` holds with a stable `rd_data` and `sclk` low until `rd_ready` is seen. Only then does the next byte start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Transaction request present |
| req_ready | output | 1 | Engine idle and able to accept a request |
| req_cmd | input | 8 | Command byte, sent first |
| req_rd | input | 1 | 1 = read data phase, 0 = write data phase |
| req_len | input | LEN_W | Number of data bytes (0 = command only) |
| wr_valid | input | 1 | Write byte available |
| wr_ready | output | 1 | Engine takes the write byte |
| wr_data | input | 8 | Write byte |
| rd_valid | output | 1 | Received byte available |
| rd_ready | input | 1 | Host takes the received byte |
| rd_data | output | 8 | Received byte |
| busy | output | 1 | Transaction in progress |
| ce | output | 1 | Active-high chip enable |
| sclk | output | 1 | Serial clock, rests low |
| dq_o | output | 1 | Data line output value |
| dq_oe | output | 1 | Data line output enable |
| dq_i | input | 1 | Data line input value |

## Verification
The hardest point to reach is the turnaround. It needs a read whose peripheral model begins driving at the same falling edge where the master lets go of the line, and a host that then stalls on the received bytes. The bench runs a slave model clocked by `sclk` that starts driving at the falling edge after the eighth command edge. It checks at every rising edge that the output enable is already low. A second phase throttles `rd_ready` so the clock must stall while the received byte is held. Write bursts are also stretched by withholding `wr_valid` for many cycles, to show the clock waits low in the gap.

// File: rtl/tw_pkg.sv
package tw_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CMD,
    ST_WGAP,
    ST_WBIT,
    ST_RBIT,
    ST_RHOLD,
    ST_TAIL
  } tw_state_e;

  // system cycles per serial half period, rounded up so the rate never exceeds target
  function automatic int half_cycles(input int sys_hz, input int sclk_hz);
    return (sys_hz + 2 * sclk_hz - 1) / (2 * sclk_hz);
  endfunction

endpackage

// File: rtl/tw_clkdiv.sv
module tw_clkdiv #(
  parameter int HALF = 13,
  parameter int CW   = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);

  logic [CW-1:0] cnt_q, cnt_n;

  always_comb begin
    tick  = run && (cnt_q == CW'(HALF - 1));
    cnt_n = (!run || tick) ? '0 : cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end

endmodule

// File: rtl/tw_shifter.sv
module tw_shifter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         tx_step,
  input  logic         rx_step,
  input  logic         dq_i,
  output logic         tx_bit,
  output logic [W-1:0] rx_byte
);

  logic [W-1:0] tx_q, tx_n, rx_q, rx_n;

  always_comb begin
    tx_n = tx_q;
    if (load)         tx_n = load_val;
    else if (tx_step) tx_n = {1'b0, tx_q[W-1:1]};
    rx_n = rx_step ? {dq_i, rx_q[W-1:1]} : rx_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q <= '0;
      rx_q <= '0;
    end else begin
      tx_q <= tx_n;
      rx_q <= rx_n;
    end
  end

  assign tx_bit  = tx_q[0];
  assign rx_byte = rx_q;

endmodule

// File: rtl/tw_ctrl.sv
module tw_ctrl
  import tw_pkg::*;
#(
  parameter int LEN_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_rd,
  input  logic [LEN_W-1:0] req_len,
  output logic             req_ready,
  input  logic             wr_valid,
  output logic             wr_ready,
  output logic             rd_valid,
  input  logic             rd_ready,
  input  logic             tick,
  output logic             run,
  output logic             sclk,
  output logic             ce,
  output logic             dq_oe,
  output logic             load_cmd,
  output logic             load_wr,
  output logic             tx_step,
  output logic             rx_step
);

  tw_state_e        st_q, st_n;
  logic             sclk_q, sclk_n;
  logic             ce_q, ce_n;
  logic             oe_q, oe_n;
  logic             rdm_q, rdm_n;
  logic [2:0]       bit_q, bit_n;
  logic [LEN_W-1:0] rem_q, rem_n;
  logic             shifting;

  assign shifting = (st_q == ST_CMD) || (st_q == ST_WBIT) || (st_q == ST_RBIT);

  always_comb begin
    st_n     = st_q;
    sclk_n   = sclk_q;
    ce_n     = ce_q;
    oe_n     = oe_q;
    rdm_n    = rdm_q;
    bit_n    = bit_q;
    rem_n    = rem_q;
    load_cmd = 1'b0;
    load_wr  = 1'b0;
    tx_step  = 1'b0;
    rx_step  = 1'b0;

    case (st_q)
      ST_IDLE: begin
        if (req_valid) begin
          st_n     = ST_CMD;
          ce_n     = 1'b1;
          oe_n     = 1'b1;
          rdm_n    = req_rd;
          rem_n    = req_len;
          bit_n    = 3'd0;
          load_cmd = 1'b1;
        end
      end
      ST_CMD, ST_WBIT, ST_RBIT: begin
        if (tick) begin
          if (!sclk_q) begin
            // end of low phase: rising edge, read bit captured here
            sclk_n  = 1'b1;
            rx_step = (st_q == ST_RBIT);
          end else begin
            // end of high phase: falling edge, next bit launched here
            sclk_n = 1'b0;
            if (bit_q != 3'd7) begin
              bit_n   = bit_q + 3'd1;
              tx_step = (st_q != ST_RBIT);
            end else begin
              bit_n = 3'd0;
              case (st_q)
                ST_CMD: begin
                  if (rdm_q) oe_n = 1'b0;
                  if (rem_q == '0) st_n = ST_TAIL;
                  else             st_n = rdm_q ? ST_RBIT : ST_WGAP;
                end
                ST_WBIT: begin
                  rem_n = rem_q - LEN_W'(1);
                  st_n  = (rem_q == LEN_W'(1)) ? ST_TAIL : ST_WGAP;
                end
                default: begin
                  rem_n = rem_q - LEN_W'(1);
                  st_n  = ST_RHOLD;
                end
              endcase
            end
          end
        end
      end
      ST_WGAP: begin
        if (wr_valid) begin
          load_wr = 1'b1;
          st_n    = ST_WBIT;
        end
      end
      ST_RHOLD: begin
        if (rd_ready) st_n = (rem_q == '0) ? ST_TAIL : ST_RBIT;
      end
      ST_TAIL: begin
        if (tick) begin
          st_n = ST_IDLE;
          ce_n = 1'b0;
          oe_n = 1'b0;
        end
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      sclk_q <= 1'b0;
      ce_q   <= 1'b0;
      oe_q   <= 1'b0;
      rdm_q  <= 1'b0;
      bit_q  <= 3'd0;
      rem_q  <= '0;
    end else begin
      st_q   <= st_n;
      sclk_q <= sclk_n;
      ce_q   <= ce_n;
      oe_q   <= oe_n;
      rdm_q  <= rdm_n;
      bit_q  <= bit_n;
      rem_q  <= rem_n;
    end
  end

  assign run       = shifting || (st_q == ST_TAIL);
  assign req_ready = (st_q == ST_IDLE);
  assign wr_ready  = (st_q == ST_WGAP);
  assign rd_valid  = (st_q == ST_RHOLD);
  assign sclk      = sclk_q;
  assign ce        = ce_q;
  assign dq_oe     = oe_q;

endmodule

// File: rtl/tw_serial_master.sv
module tw_serial_master
  import tw_pkg::*;
#(
  parameter int SYS_HZ       = 50_000_000,
  parameter int SCLK_FAST_HZ = 2_000_000,
  parameter int SCLK_SLOW_HZ = 500_000,
  parameter bit LOW_VOLT     = 1'b0,
  parameter int LEN_W        = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [7:0]       req_cmd,
  input  logic             req_rd,
  input  logic [LEN_W-1:0] req_len,
  input  logic             wr_valid,
  output logic             wr_ready,
  input  logic [7:0]       wr_data,
  output logic             rd_valid,
  input  logic             rd_ready,
  output logic [7:0]       rd_data,
  output logic             busy,
  output logic             ce,
  output logic             sclk,
  output logic             dq_o,
  output logic             dq_oe,
  input  logic             dq_i
);

  localparam int SCLK_HZ = LOW_VOLT ? SCLK_SLOW_HZ : SCLK_FAST_HZ;
  localparam int HALF    = half_cycles(SYS_HZ, SCLK_HZ);
  localparam int CW      = $clog2(HALF + 1);

  logic       tick, run;
  logic       load_cmd, load_wr, tx_step, rx_step;
  logic [7:0] load_val;

  assign load_val = load_cmd ? req_cmd : wr_data;

  tw_clkdiv #(.HALF(HALF), .CW(CW)) u_div (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (run),
    .tick (tick)
  );

  tw_ctrl #(.LEN_W(LEN_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_rd   (req_rd),
    .req_len  (req_len),
    .req_ready(req_ready),
    .wr_valid (wr_valid),
    .wr_ready (wr_ready),
    .rd_valid (rd_valid),
    .rd_ready (rd_ready),
    .tick     (tick),
    .run      (run),
    .sclk     (sclk),
    .ce       (ce),
    .dq_oe    (dq_oe),
    .load_cmd (load_cmd),
    .load_wr  (load_wr),
    .tx_step  (tx_step),
    .rx_step  (rx_step)
  );

  tw_shifter #(.W(8)) u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (load_cmd | load_wr),
    .load_val(load_val),
    .tx_step (tx_step),
    .rx_step (rx_step),
    .dq_i    (dq_i),
    .tx_bit  (dq_o),
    .rx_byte (rd_data)
  );

  assign busy = ce;

endmodule

// File: rtl/tw_serial_master_chk.sv
module tw_serial_master_chk #(
  parameter int HALF = 13
) (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       req_ready,
  input logic       wr_ready,
  input logic       rd_valid,
  input logic       rd_ready,
  input logic [7:0] rd_data,
  input logic       busy,
  input logic       ce,
  input logic       sclk,
  input logic       dq_o,
  input logic       dq_oe
);

  logic [15:0] hi_cnt, lo_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_cnt <= '0;
      lo_cnt <= '0;
    end else begin
      hi_cnt <= sclk ? hi_cnt + 16'd1 : 16'd0;
      lo_cnt <= sclk ? 16'd0 : lo_cnt + 16'd1;
    end
  end

  // R1
  idle_clk_low_chk: assert property (@(posedge clk) disable iff (!rst_n) !ce |-> !sclk);
  // R10
  ce_start_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(ce) |-> $past(req_valid && req_ready));
  // R10
  busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n) busy |-> !req_ready);
  // R3
  tx_change_low_chk: assert property (@(posedge clk) disable iff (!rst_n) (ce && !$stable(dq_o)) |-> !sclk);
  // R6
  oe_release_chk: assert property (@(posedge clk) disable iff (!rst_n) ($fell(dq_oe) && ce) |-> (!sclk && $past(sclk)));
  // R7
  high_len_chk: assert property (@(posedge clk) disable iff (!rst_n) $fell(sclk) |-> (hi_cnt == 16'(HALF)));
  // R7
  low_len_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(sclk) |-> (lo_cnt >= 16'(HALF)));
  // R11
  wr_gap_chk: assert property (@(posedge clk) disable iff (!rst_n) wr_ready |-> (ce && !sclk));
  // R12
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data) && !sclk));

endmodule

bind tw_serial_master tw_serial_master_chk #(.HALF(HALF)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_valid(req_valid),
  .req_ready(req_ready),
  .wr_ready (wr_ready),
  .rd_valid (rd_valid),
  .rd_ready (rd_ready),
  .rd_data  (rd_data),
  .busy     (busy),
  .ce       (ce),
  .sclk     (sclk),
  .dq_o     (dq_o),
  .dq_oe    (dq_oe)
);

// File: tb/sim_tw_serial_master.sv
`timescale 1ns/1ps
module sim_tw_serial_master;

  localparam int LEN_W = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic             req_valid = 0, req_rd = 0, wr_valid = 0, rd_ready = 1, dq_i = 0;
  logic [7:0]       req_cmd = 0, wr_data = 0;
  logic [LEN_W-1:0] req_len = 0;
  logic             req_ready, wr_ready, rd_valid, busy, ce, sclk, dq_o, dq_oe;
  logic [7:0]       rd_data;

  tw_serial_master #(.LEN_W(LEN_W)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_cmd(req_cmd), .req_rd(req_rd), .req_len(req_len),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .busy(busy), .ce(ce), .sclk(sclk), .dq_o(dq_o), .dq_oe(dq_oe), .dq_i(dq_i)
  );

  // slow-setting instance, used only for clock rate
  logic             req1_valid = 0;
  logic             req1_ready, wr1_ready, rd1_valid, busy1, ce1, sclk1, dq1_o, dq1_oe;
  logic [7:0]       rd1_data;
  tw_serial_master #(.LEN_W(LEN_W), .LOW_VOLT(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n), .req_valid(req1_valid), .req_ready(req1_ready),
    .req_cmd(8'h3C), .req_rd(1'b0), .req_len('0),
    .wr_valid(1'b0), .wr_ready(wr1_ready), .wr_data(8'h00),
    .rd_valid(rd1_valid), .rd_ready(1'b1), .rd_data(rd1_data),
    .busy(busy1), .ce(ce1), .sclk(sclk1), .dq_o(dq1_o), .dq_oe(dq1_oe), .dq_i(1'b0)
  );

  int checks = 0;
  int errors = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // scoreboard queues
  logic [7:0] exp_w[$];
  logic [7:0] exp_r[$];
  logic [7:0] wsrc[$];
  logic [7:0] slave_rd[16];
  bit         cur_rd = 0;
  bit         wr_slow = 0;
  bit         rd_stall = 0;
  int         rise_cnt = 0;
  int         ce_rises = 0;
  logic [7:0] cmd_seen = 0;
  logic [7:0] wbyte = 0;

  // slave: sample on rising sclk
  initial forever begin
    @(posedge sclk);
    if (ce) begin
      if (rise_cnt < 8) begin
        cmd_seen[rise_cnt] = dq_o;
        if (rise_cnt == 7) chk(dq_oe, "R6 oe held through cmd", dq_oe, 1);
      end else if (!cur_rd) begin
        wbyte[(rise_cnt - 8) % 8] = dq_o;
        if ((rise_cnt - 8) % 8 == 7) begin
          if (exp_w.size() == 0) chk(0, "R9 extra write byte", wbyte, 0);
          else begin
            logic [7:0] e;
            e = exp_w.pop_front();
            chk(wbyte == e, "R2 R3 write byte", wbyte, e);
          end
        end
      end else begin
        chk(!dq_oe, "R6 released in read phase", dq_oe, 0);
      end
      rise_cnt++;
    end
  end

  // slave: launch read bits after falling sclk
  initial forever begin
    @(negedge sclk);
    if (ce && cur_rd && rise_cnt >= 8) begin
      int idx;
      idx = rise_cnt - 8;
      if (idx < 128) dq_i = slave_rd[idx / 8][idx % 8];
    end
  end

  initial forever begin
    @(posedge ce);
    ce_rises++;
  end

  // write driver
  initial forever begin
    @(negedge clk);
    if (wr_ready && wsrc.size() > 0) begin
      if (wr_slow) begin
        wr_valid = 0;
        for (int i = 0; i < 30; i++) begin
          @(negedge clk);
          chk(!sclk && ce && wr_ready, "R11 clock waits in gap", {ce, sclk}, 2);
        end
      end
      wr_data  = wsrc[0];
      wr_valid = 1;
      @(posedge clk);
      #1;
      void'(wsrc.pop_front());
      wr_valid = 0;
    end
  end

  // read ready driver
  int cyc = 0;
  initial forever begin
    @(negedge clk);
    cyc++;
    rd_ready = rd_stall ? (cyc % 4 == 0) : 1'b1;
  end

  // read monitor
  bit         held = 0;
  logic [7:0] held_val = 0;
  initial forever begin
    @(negedge clk);
    if (held) begin
      chk(rd_valid && rd_data == held_val && !sclk, "R12 byte held", rd_data, held_val);
      held = 0;
    end
    if (rd_valid && rd_ready) begin
      if (exp_r.size() == 0) chk(0, "R9 extra read byte", rd_data, 0);
      else begin
        logic [7:0] e;
        e = exp_r.pop_front();
        chk(rd_data == e, "R4 read byte", rd_data, e);
      end
    end else if (rd_valid) begin
      held = 1;
      held_val = rd_data;
    end
  end

  task automatic do_xfer(input logic [7:0] cmd, input bit rd, input int len, input logic [7:0] seed);
    for (int i = 0; i < len; i++) begin
      logic [7:0] b;
      b = seed ^ 8'(i * 37 + 1);
      if (rd) begin
        slave_rd[i] = b;
        exp_r.push_back(b);
      end else begin
        exp_w.push_back(b);
        wsrc.push_back(b);
      end
    end
    cur_rd   = rd;
    rise_cnt = 0;
    ce_rises = 0;
    @(negedge clk);
    chk(req_ready && !busy, "R10 ready when idle", req_ready, 1);
    req_cmd   = cmd;
    req_rd    = rd;
    req_len   = LEN_W'(len);
    req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    chk(busy && !req_ready, "R10 busy after accept", busy, 1);
    @(negedge ce);
    @(negedge clk);
    chk(rise_cnt == 8 + 8 * len, "R5 R9 edges in frame", rise_cnt, 8 + 8 * len);
    chk(ce_rises == 1, "R5 single enable pulse", ce_rises, 1);
    chk(cmd_seen == cmd, "R2 command LSB first", cmd_seen, cmd);
    chk(exp_w.size() == 0 && exp_r.size() == 0, "R9 all bytes moved", exp_w.size() + exp_r.size(), 0);
    chk(!sclk && !busy && req_ready && !dq_oe, "R1 rest state", {sclk, busy, req_ready, dq_oe}, 2);
  endtask

  task automatic meas(input bit which, input bit lvl, output int n);
    n = 0;
    do begin
      @(posedge clk);
      #1;
      n++;
    end while (((which ? sclk1 : sclk) == lvl) && n < 1000);
  endtask

  task automatic run_tests();
    int nh, nl;
    repeat (3) @(negedge clk);
    chk(!ce && !sclk && !dq_oe && !busy && req_ready, "R1 reset state",
        {ce, sclk, dq_oe, busy, req_ready}, 1);
    rst_n = 1;
    repeat (3) @(negedge clk);

    do_xfer(8'h8E, 0, 1, 8'h4B);
    do_xfer(8'h8F, 1, 1, 8'h2C);
    do_xfer(8'h00, 0, 0, 8'h00);
    do_xfer(8'h81, 1, 0, 8'h00);
    do_xfer(8'hBE, 0, 8, 8'h96);
    do_xfer(8'hBF, 1, 8, 8'h5A);

    // write gap stretched by host
    wr_slow = 1;
    do_xfer(8'h42, 0, 3, 8'hE1);
    wr_slow = 0;

    // read with back-pressure
    rd_stall = 1;
    do_xfer(8'h43, 1, 4, 8'h17);
    rd_stall = 0;

    // maximum count
    do_xfer(8'hC2, 0, 15, 8'h33);

    // request during busy is ignored
    fork
      do_xfer(8'hA6, 0, 2, 8'h70);
      begin
        repeat (20) @(negedge clk);
        req_cmd   = 8'h11;
        req_valid = 1;
        for (int i = 0; i < 200; i++) begin
          @(negedge clk);
          if (i % 50 == 0) chk(!req_ready && busy, "R10 request blocked", req_ready, 0);
        end
        req_valid = 0;
      end
    join
    repeat (5) @(negedge clk);
    chk(!ce && ce_rises == 1, "R10 no second frame", ce_rises, 1);

    // fast clock rate
    fork
      do_xfer(8'h5D, 0, 0, 8'h00);
      begin
        @(posedge sclk);
        meas(0, 1, nh);
        meas(0, 0, nl);
        chk(nh == 13, "R7 high phase", nh, 13);
        chk(nl == 13, "R7 low phase", nl, 13);
      end
    join

    // slow clock rate
    fork
      begin
        @(negedge clk);
        req1_valid = 1;
        @(negedge clk);
        req1_valid = 0;
      end
      begin
        @(posedge sclk1);
        meas(1, 1, nh);
        meas(1, 0, nl);
        chk(nh == 50, "R8 slow high phase", nh, 50);
        chk(nl == 50, "R8 slow low phase", nl, 50);
      end
    join
    @(negedge ce1);
    repeat (3) @(negedge clk);
    chk(!sclk1 && req1_ready, "R1 slow rest state", sclk1, 0);
  endtask

  initial begin
    fork
      run_tests();
      begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule